// File: doc/BRIEF.md
# Input Capture Timestamp FIFO

This block holds timer values latched by capture events until a 16-bit processor bus reads them out. On each accepted capture the current timer value is written into a small first-in first-out store. The store holds either four 16-bit entries or two 32-bit entries, and a mode input chooses between them. A 32-bit entry is read in two 16-bit accesses. The entry is released only when its upper half is read.

Two status outputs report the store. `not_empty` is high while unread entries remain. `overflow` is a sticky flag that is set when a capture arrives at a full store. After an overflow the block accepts no more captures until the store has been drained. Software can also write the overflow flag to zero, which discards everything and rewinds both pointers to the first slot. A programmable event count raises a single-cycle interrupt pulse after the chosen number of accepted captures. Deasserting `enable` empties the store and clears the flags.

Top module: `ic_ts_fifo`

## Requirements
- R1: With `wide`=0 the store holds four 16-bit entries. With `wide`=1 it holds two 32-bit entries. A capture beyond that depth is never stored.
- R2: `not_empty` rises after the first accepted capture. It stays high until every stored entry has been popped, so N stored entries need N popping reads.
- R3: In an overflow-capable mode, a capture that arrives while the store is full sets `overflow`, and its value is discarded.
- R4: While `overflow` is set and entries remain, every capture is ignored. Once the reads have drained the store, captures are stored again, and `overflow` stays set.
- R5: A pulse on `ov_clr` clears `overflow` and `not_empty`, discards all entries, returns both pointers to slot 0 and restarts the interrupt count.
- R6: A read while the store is empty returns the contents of slot 0, does not pop, and leaves `not_empty` low.
- R7: `rd_data` is registered and updates in the cycle after `rd_en`. With `wide`=1, `rd_addr`=0 returns bits 15:0 of the head entry without popping, and `rd_addr`=1 returns bits 31:16 and pops. With `wide`=0 every read pops the head, and `rd_addr` is ignored.
- R8: The `mode` field is decoded as follows. When `mode[3]`=1 the block is not in capture mode and captures are ignored. `mode`=4'b0000 is edge-detect: captures are stored, and a capture into a full store is dropped without setting `overflow`. `mode` values 4'b0001 to 4'b0111 are capture modes in which overflow can occur.
- R9: While `enable` is low, both flags are low, the store is empty, captures are ignored, the interrupt count is cleared, and reads return 0.
- R10: `irq` is a one-cycle pulse, asserted in the cycle after the accepted capture that completes a group of `int_cnt`+1 captures (codes 0 to 3 select 1 to 4 captures). With `wide`=1 the group size is limited to 2.
- R11: A capture and a popping read in the same cycle are both carried out. The occupancy count is unchanged and the order of the entries is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Module on; low empties the store and clears flags |
| mode | input | 4 | Operating mode field (see R8) |
| wide | input | 1 | 1 = two 32-bit entries, 0 = four 16-bit entries |
| int_cnt | input | 2 | Captures per interrupt, minus one |
| cap_evt | input | 1 | Capture strobe |
| timer_val | input | 32 | Timer value latched on a capture |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | Half select in 32-bit mode (0 low, 1 high) |
| ov_clr | input | 1 | Software write of zero to the overflow flag |
| rd_data | output | 16 | Registered read data |
| not_empty | output | 1 | Unread entries present |
| overflow | output | 1 | Sticky overflow flag |
| irq | output | 1 | Capture-count interrupt pulse |

## Verification
The hardest state to reach is the overflow lockout while entries are still stored. To get there, the bench fills the store, sends one more capture to set the flag, and pops a single entry so that room exists again. It then sends a further capture, which must not land. Draining the rest and finding the original sequence, with `not_empty` falling exactly at its end, shows that the capture was refused. The bench then captures after the drain to show that storing resumes while the flag is still set. A cycle in which a capture and a pop coincide is checked by refilling afterwards: the store must take exactly as many entries as an unchanged count allows before overflow appears.

// File: rtl/ic_ts_pkg.sv
package ic_ts_pkg;

  localparam int unsigned MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_EDGE = '0;

  // captures are taken only when the top mode bit is clear
  function automatic logic mode_captures(input logic [MODE_W-1:0] m);
    return !m[MODE_W-1];
  endfunction

  // overflow may be raised only in true capture modes
  function automatic logic mode_can_overflow(input logic [MODE_W-1:0] m);
    return !m[MODE_W-1] && (m != MODE_EDGE);
  endfunction

endpackage

// File: rtl/ic_bank.sv
module ic_bank #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned N      = 2
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [$clog2(N)-1:0]       widx,
  input  logic [WORD_W-1:0]          wdata,
  input  logic [$clog2(N)-1:0]       ridx,
  output logic [WORD_W-1:0]          rdata
);

  logic [WORD_W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/ic_fifo_ctrl.sv
module ic_fifo_ctrl #(
  parameter int unsigned DEPTH16 = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            enable,
  input  logic                            wide,
  input  logic                            cap_evt,
  input  logic                            cap_ok,
  input  logic                            ov_ok,
  input  logic                            pop_req,
  input  logic                            ov_clr,
  output logic                            push,
  output logic                            pop,
  output logic [$clog2(DEPTH16)-1:0]      wr_ptr,
  output logic [$clog2(DEPTH16)-1:0]      rd_ptr,
  output logic [$clog2(DEPTH16+1)-1:0]    count,
  output logic                            not_empty,
  output logic                            overflow
);

  localparam int unsigned PW = $clog2(DEPTH16);
  localparam int unsigned CW = $clog2(DEPTH16 + 1);

  logic [CW-1:0] depth_cur;
  logic [PW-1:0] last_idx;
  logic          full, locked, can_pop, ov_set, active;
  logic [PW-1:0] wr_nxt, rd_nxt;
  logic [CW-1:0] count_nxt;

  assign depth_cur = wide ? CW'(DEPTH16 / 2) : CW'(DEPTH16);
  assign last_idx  = wide ? PW'(DEPTH16 / 2 - 1) : PW'(DEPTH16 - 1);
  assign full      = (count == depth_cur);
  assign locked    = overflow && (count != '0);
  assign active    = enable && !ov_clr;
  assign can_pop   = pop_req && (count != '0);

  assign pop    = active && can_pop;
  assign push   = active && cap_evt && cap_ok && !locked && (!full || can_pop);
  assign ov_set = active && cap_evt && cap_ok && ov_ok && !locked && full && !can_pop;

  assign wr_nxt    = (wr_ptr == last_idx) ? '0 : wr_ptr + PW'(1);
  assign rd_nxt    = (rd_ptr == last_idx) ? '0 : rd_ptr + PW'(1);
  assign count_nxt = count + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (rst || !enable || ov_clr) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      not_empty <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (pop && !push && count == CW'(1)) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push) wr_ptr <= wr_nxt;
        if (pop)  rd_ptr <= rd_nxt;
      end
      count     <= count_nxt;
      not_empty <= (count_nxt != '0);
      if (ov_set) overflow <= 1'b1;
    end
  end

  p_depth_r1: assert property (@(posedge clk) disable iff (rst)
    $stable(wide) |-> (count <= depth_cur));
  p_fill_r2: assert property (@(posedge clk) disable iff (rst)
    push |=> not_empty);
  p_lockout_r4: assert property (@(posedge clk) disable iff (rst)
    (overflow && not_empty) |-> !push);
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    ov_clr |=> (!overflow && !not_empty && rd_ptr == '0 && wr_ptr == '0));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (!ov_ok && !overflow) |=> !overflow);
  p_off_r9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!overflow && !not_empty));

endmodule

// File: rtl/ic_irq_gen.sv
module ic_irq_gen #(
  parameter int unsigned DEPTH16 = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enable,
  input  logic                         ov_clr,
  input  logic                         wide,
  input  logic                         push,
  input  logic [$clog2(DEPTH16)-1:0]   int_cnt,
  output logic                         irq
);

  localparam int unsigned CW = $clog2(DEPTH16 + 1);

  logic [CW-1:0] seen, want, want_raw;
  logic          hit;

  assign want_raw = CW'(int_cnt) + CW'(1);
  assign want     = (wide && want_raw > CW'(DEPTH16 / 2)) ? CW'(DEPTH16 / 2) : want_raw;
  assign hit      = push && ((seen + CW'(1)) == want);

  always_ff @(posedge clk) begin
    if (rst || !enable || ov_clr) begin
      seen <= '0;
      irq  <= 1'b0;
    end else begin
      irq <= hit;
      if (hit)       seen <= '0;
      else if (push) seen <= seen + CW'(1);
    end
  end

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(push));

endmodule

// File: rtl/ic_ts_fifo.sv
module ic_ts_fifo #(
  parameter int unsigned DEPTH16 = 4,
  parameter int unsigned WORD_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        enable,
  input  logic [3:0]                  mode,
  input  logic                        wide,
  input  logic [$clog2(DEPTH16)-1:0]  int_cnt,
  input  logic                        cap_evt,
  input  logic [2*WORD_W-1:0]         timer_val,
  input  logic                        rd_en,
  input  logic                        rd_addr,
  input  logic                        ov_clr,
  output logic [WORD_W-1:0]           rd_data,
  output logic                        not_empty,
  output logic                        overflow,
  output logic                        irq
);
  import ic_ts_pkg::*;

  localparam int unsigned PW    = $clog2(DEPTH16);
  localparam int unsigned CW    = $clog2(DEPTH16 + 1);
  localparam int unsigned NBANK = DEPTH16 / 2;
  localparam int unsigned IW    = $clog2(NBANK);

  logic          push, pop, pop_req, cap_ok, ov_ok;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [IW-1:0] widx, ridx;
  logic [WORD_W-1:0] bank_q [2];
  logic [WORD_W-1:0] word;

  assign cap_ok  = mode_captures(mode);
  assign ov_ok   = mode_can_overflow(mode);
  assign pop_req = rd_en && (!wide || rd_addr);

  ic_fifo_ctrl #(.DEPTH16(DEPTH16)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .wide(wide),
    .cap_evt(cap_evt), .cap_ok(cap_ok), .ov_ok(ov_ok),
    .pop_req(pop_req), .ov_clr(ov_clr),
    .push(push), .pop(pop), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(count), .not_empty(not_empty), .overflow(overflow)
  );

  ic_irq_gen #(.DEPTH16(DEPTH16)) u_irq (
    .clk(clk), .rst(rst), .enable(enable), .ov_clr(ov_clr), .wide(wide),
    .push(push), .int_cnt(int_cnt), .irq(irq)
  );

  // 16-bit mode: even slots in bank 0, odd in bank 1; 32-bit: low/high halves
  assign widx = wide ? wr_ptr[IW-1:0] : wr_ptr[PW-1:1];
  assign ridx = wide ? rd_ptr[IW-1:0] : rd_ptr[PW-1:1];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic              we;
    logic [WORD_W-1:0] wd;
    assign we = push && (wide || (wr_ptr[0] == 1'(b)));
    if (b == 0) begin : g_lo
      assign wd = timer_val[WORD_W-1:0];
    end else begin : g_hi
      assign wd = wide ? timer_val[2*WORD_W-1:WORD_W] : timer_val[WORD_W-1:0];
    end
    ic_bank #(.WORD_W(WORD_W), .N(NBANK)) u_bank (
      .clk(clk), .we(we), .widx(widx), .wdata(wd),
      .ridx(ridx), .rdata(bank_q[b])
    );
  end

  assign word = wide ? (rd_addr ? bank_q[1] : bank_q[0])
                     : (rd_ptr[0] ? bank_q[1] : bank_q[0]);

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= enable ? word : '0;
  end

  p_half_read_r7: assert property (@(posedge clk) disable iff (rst)
    (enable && rd_en && wide && !rd_addr && !ov_clr) |=> $stable(rd_ptr));
  p_pair_r11: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(count));

endmodule

// File: tb/ic_ts_fifo_bench.sv
module ic_ts_fifo_bench;

  logic        clk = 0, rst = 1, enable = 0, wide = 0;
  logic [3:0]  mode = 4'b0001;
  logic [1:0]  int_cnt = 0;
  logic        cap_evt = 0, rd_en = 0, rd_addr = 0, ov_clr = 0;
  logic [31:0] timer_val = 0;
  logic [15:0] rd_data;
  logic        not_empty, overflow, irq;
  int checks = 0, errors = 0;
  logic        last_irq;

  always #5 clk = ~clk;

  ic_ts_fifo u_ic_ts_fifo (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode), .wide(wide),
    .int_cnt(int_cnt), .cap_evt(cap_evt), .timer_val(timer_val),
    .rd_en(rd_en), .rd_addr(rd_addr), .ov_clr(ov_clr),
    .rd_data(rd_data), .not_empty(not_empty), .overflow(overflow), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic capture(input logic [31:0] v);
    @(negedge clk); cap_evt = 1; timer_val = v;
    @(negedge clk); cap_evt = 0; last_irq = irq;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic clr();
    @(negedge clk); ov_clr = 1;
    @(negedge clk); ov_clr = 0;
  endtask

  task automatic t_reset();
    chk("R9 reset rd_data", 32'(rd_data), 0);
    chk("R2 reset not_empty", 32'(not_empty), 0);
    chk("R3 reset overflow", 32'(overflow), 0);
    chk("R10 reset irq", 32'(irq), 0);
  endtask

  task automatic t_fifo16();
    logic [15:0] d;
    mode = 4'b0001; wide = 0; clr();
    for (int i = 1; i <= 4; i++) capture(32'(i * 16'h1111));
    chk("R2 not_empty after fill", 32'(not_empty), 1);
    chk("R1 no overflow at four", 32'(overflow), 0);
    capture(32'h5555);
    chk("R3 overflow on fifth", 32'(overflow), 1);
    for (int i = 1; i <= 4; i++) begin
      rd(1'(i % 2), d);
      chk("R7 16-bit order", 32'(d), 32'(i * 16'h1111));
      chk("R2 not_empty while draining", 32'(not_empty), (i < 4) ? 1 : 0);
    end
    chk("R4 overflow sticky after drain", 32'(overflow), 1);
    capture(32'h6666);
    chk("R4 capture resumes after drain", 32'(not_empty), 1);
    rd(0, d);
    chk("R4 resumed value", 32'(d), 32'h6666);
  endtask

  task automatic t_lockout();
    logic [15:0] d;
    clr();
    for (int i = 1; i <= 4; i++) capture(32'(i));
    capture(32'h99);
    rd(0, d);
    chk("R4 first pop", 32'(d), 1);
    capture(32'h7777);
    for (int i = 2; i <= 4; i++) begin
      rd(0, d);
      chk("R4 locked capture not stored", 32'(d), 32'(i));
    end
    chk("R4 empty after three", 32'(not_empty), 0);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    capture(32'h0A0A); capture(32'h0B0B);
    clr();
    chk("R5 clear drops not_empty", 32'(not_empty), 0);
    chk("R5 clear drops overflow", 32'(overflow), 0);
    capture(32'h0009);
    rd(0, d);
    chk("R5 data discarded, restart at slot 0", 32'(d), 32'h0009);
  endtask

  task automatic t_empty_read();
    logic [15:0] d;
    capture(32'h00A1); capture(32'h00A2);
    rd(0, d); rd(0, d);
    chk("R6 second value", 32'(d), 32'h00A2);
    rd(0, d);
    chk("R6 empty read gives slot 0", 32'(d), 32'h00A1);
    chk("R6 still empty", 32'(not_empty), 0);
  endtask

  task automatic t_wide();
    logic [15:0] d;
    clr(); wide = 1;
    capture(32'hAAAA_0001); capture(32'hBBBB_0002);
    chk("R1 two wide entries no overflow", 32'(overflow), 0);
    capture(32'hCCCC_0003);
    chk("R1 third wide entry overflows", 32'(overflow), 1);
    rd(0, d); chk("R7 low half", 32'(d), 32'h0001);
    rd(0, d); chk("R7 low half no pop", 32'(d), 32'h0001);
    rd(1, d); chk("R7 high half", 32'(d), 32'hAAAA);
    chk("R2 one wide entry left", 32'(not_empty), 1);
    rd(0, d); chk("R7 second low", 32'(d), 32'h0002);
    rd(1, d); chk("R7 second high", 32'(d), 32'hBBBB);
    chk("R2 wide drained", 32'(not_empty), 0);
  endtask

  task automatic t_modes();
    logic [15:0] d;
    clr(); wide = 0; mode = 4'b1000;
    capture(32'h1234);
    chk("R8 non-capture mode ignores", 32'(not_empty), 0);
    mode = 4'b0000;
    for (int i = 1; i <= 5; i++) capture(32'(16'h0100 + i));
    chk("R8 edge mode no overflow", 32'(overflow), 0);
    for (int i = 1; i <= 4; i++) begin
      rd(0, d);
      chk("R8 edge mode stored", 32'(d), 32'(16'h0100 + i));
    end
    chk("R8 fifth dropped", 32'(not_empty), 0);
    mode = 4'b0001;
  endtask

  task automatic t_simul();
    logic [15:0] d;
    clr();
    capture(32'h0011); capture(32'h0022); capture(32'h0033);
    @(negedge clk); cap_evt = 1; timer_val = 32'h00DD; rd_en = 1; rd_addr = 0;
    @(negedge clk); cap_evt = 0; rd_en = 0; d = rd_data;
    chk("R11 popped head", 32'(d), 32'h0011);
    capture(32'h0044);
    chk("R11 count unchanged, no overflow at four", 32'(overflow), 0);
    capture(32'h0055);
    chk("R11 full at four", 32'(overflow), 1);
    rd(0, d); chk("R11 order 1", 32'(d), 32'h0022);
    rd(0, d); chk("R11 order 2", 32'(d), 32'h0033);
    rd(0, d); chk("R11 order 3", 32'(d), 32'h00DD);
    rd(0, d); chk("R11 order 4", 32'(d), 32'h0044);
  endtask

  task automatic t_irq();
    clr(); wide = 0; int_cnt = 2;
    capture(1); chk("R10 no irq after 1", 32'(last_irq), 0);
    capture(2); chk("R10 no irq after 2", 32'(last_irq), 0);
    capture(3); chk("R10 irq after 3", 32'(last_irq), 1);
    @(negedge clk); chk("R10 irq one cycle", 32'(irq), 0);
    clr(); wide = 1; int_cnt = 3;
    capture(1); chk("R10 wide no irq after 1", 32'(last_irq), 0);
    capture(2); chk("R10 wide clamp irq after 2", 32'(last_irq), 1);
    clr(); wide = 0; int_cnt = 0;
  endtask

  task automatic t_disable();
    logic [15:0] d;
    for (int i = 0; i < 5; i++) capture(32'h0777);
    @(negedge clk); enable = 0;
    @(negedge clk);
    chk("R9 disable clears overflow", 32'(overflow), 0);
    chk("R9 disable clears not_empty", 32'(not_empty), 0);
    rd(0, d);
    chk("R9 read while disabled is 0", 32'(d), 0);
    capture(32'h0888);
    chk("R9 irq silent while disabled", 32'(last_irq), 0);
    @(negedge clk); enable = 1;
    @(negedge clk);
    chk("R9 capture ignored while off", 32'(not_empty), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    enable = 1;
    t_fifo16();
    t_lockout();
    t_clear();
    t_empty_read();
    t_wide();
    t_modes();
    t_simul();
    t_irq();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule